// File: doc/BRIEF.md
# Dual-Select Byte-Wide Static Memory Model

This block models a byte-wide static memory whose control pins behave like those of a classic asynchronous part. The chip is enabled only while an active-low select is low and an active-high select is high. An active-low write strobe and an active-low output enable then choose the mode: standby, output disabled, read, or write. The bidirectional bus is split into three signals: a data input, a data output, and a drive-enable flag. A pad ring or a board-level harness combines them into a tristate pin.

The decode that sets the bus drive and the write-busy flag is purely combinational. A read therefore tracks the address with no clock in the path. The write window is the overlap of both selects with the write strobe. It is sampled on a free-running clock. Address and data are captured on every edge while the window is open, and the captured word is committed to the array on the first edge after the window closes. The full address is 17 bits. The number of stored words is a parameter, so a simulation can use a small array. Address bits above the array's index width are ignored.

Top module: `sram_async_model`

## Requirements
- R1: The array stores DEPTH words of DATA_W bits. DEPTH is a power of two. Only the low log2(DEPTH) bits of the 17-bit address select a word, so addresses that differ only in higher bits reach the same word.
- R2: While csLowN is high or csHigh is low, dataOutEn is 0 and writeBusy is 0, whatever weN and oeN are.
- R3: With both selects active, weN high and oeN high, dataOutEn is 0.
- R4: With both selects active, weN high and oeN low, dataOutEn is 1 and dataOut equals the stored word at the current address. It follows an address change with no clock edge.
- R5: With both selects active and weN low, writeBusy is 1 and dataOutEn is 0, whatever oeN is.
- R6: The write window opens when the last of three conditions becomes true: csLowN low, csHigh high, weN low. It closes when the first of them becomes false. Each of the three signals can close the window, and each closing commits exactly one word.
- R7: If csLowN and weN fall in the same instant while oeN is low and csHigh is high, dataOutEn never becomes 1.
- R8: The committed word and its location are the dataIn and address sampled at the last rising clock edge at which the window was open. Values present earlier in the window are overwritten. The array holds the new word from the first rising edge after the window closes.
- R9: After reset with the chip deselected, dataOutEn and writeBusy are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the write window and commit |
| rstN | input | 1 | Active-low asynchronous reset of the window state |
| addr | input | 17 | Word address |
| dataIn | input | 8 | Write data taken from the bus |
| csLowN | input | 1 | Active-low chip select |
| csHigh | input | 1 | Active-high chip select |
| weN | input | 1 | Active-low write strobe |
| oeN | input | 1 | Active-low output enable |
| dataOut | output | 8 | Read data, zero while not driving |
| dataOutEn | output | 1 | High while the bus must be driven |
| writeBusy | output | 1 | High while the write window is open |

## Verification
dataOutEn, dataOut and writeBusy are combinational, so they are due in the same instant as the control change. The bench drives every input on a falling clock edge and samples one time unit later, before any rising edge can intervene. A write lands in the array on the first rising edge after its window closes. The bench therefore waits until the next falling edge before it updates its reference array and issues any read. Mid-window changes of address and data are checked against the values held at the last rising edge inside the window.

// File: rtl/sram_pkg.sv
package sram_pkg;
  typedef struct packed {
    logic drive;    // bus must be driven with read data
    logic capture;  // window open: sample address and data
    logic commit;   // window just closed: write captured word
  } sramStrobes_t;
endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         csLowN,
  input  logic         csHigh,
  input  logic         weN,
  input  logic         oeN,
  output sramStrobes_t strobes,
  output logic         writeBusy
);
  logic chipOn;
  logic winOpen;
  logic winQ;

  assign chipOn  = !csLowN && csHigh;
  assign winOpen = chipOn && !weN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winQ <= 1'b0;
    else       winQ <= winOpen;
  end

  always_comb begin
    strobes.drive   = chipOn && weN && !oeN;
    strobes.capture = winOpen;
    strobes.commit  = winQ && !winOpen;
  end

  assign writeBusy = winOpen;
endmodule

// File: rtl/sram_datapath.sv
module sram_datapath
  import sram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  sramStrobes_t      strobes,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  capIdx;
  logic [DATA_W-1:0] capData;

  assign idx = addr[IDX_W-1:0];

  generate
    if (IDX_W < ADDR_W) begin : g_hiBits
      logic unusedAddrHi;
      assign unusedAddrHi = ^addr[ADDR_W-1:IDX_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capIdx  <= '0;
      capData <= '0;
    end else if (strobes.capture) begin
      capIdx  <= idx;
      capData <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.commit) mem[capIdx] <= capData;
  end

  assign dataOutEn = strobes.drive;
  assign dataOut   = strobes.drive ? mem[idx] : '0;
endmodule

// File: rtl/sram_async_model.sv
module sram_async_model
  import sram_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              csLowN,
  input  logic              csHigh,
  input  logic              weN,
  input  logic              oeN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn,
  output logic              writeBusy
);
  sramStrobes_t strobes;

  sram_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .csLowN(csLowN), .csHigh(csHigh),
    .weN(weN), .oeN(oeN), .strobes(strobes), .writeBusy(writeBusy)
  );

  sram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .strobes(strobes), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/sram_async_checker.sv
module sram_async_checker (
  input logic clk,
  input logic rstN,
  input logic csLowN,
  input logic csHigh,
  input logic weN,
  input logic oeN,
  input logic dataOutEn,
  input logic writeBusy
);
  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csLowN || !csHigh) |-> (!dataOutEn && !writeBusy));

  // R3
  out_disabled_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csLowN && csHigh && weN && oeN) |-> !dataOutEn);

  // R4
  read_drives_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csLowN && csHigh && weN && !oeN) |-> dataOutEn);

  // R5
  write_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    writeBusy |-> !dataOutEn);

  // R5
  write_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csLowN && csHigh && !weN) |-> writeBusy);

  // R7
  joint_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csLowN) && $fell(weN)) |-> !dataOutEn);
endmodule

bind sram_async_model sram_async_checker u_chk (
  .clk(clk), .rstN(rstN), .csLowN(csLowN), .csHigh(csHigh),
  .weN(weN), .oeN(oeN), .dataOutEn(dataOutEn), .writeBusy(writeBusy)
);

// File: tb/sram_async_model_test.sv
module sram_async_model_test;
  localparam int PERIOD = 10;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int DEPTH = 256;

  logic clk = 0;
  logic rstN = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic csLowN = 1, csHigh = 0, weN = 1, oeN = 1;
  logic [DW-1:0] dataOut;
  logic dataOutEn, writeBusy;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];

  always #(PERIOD/2) clk = ~clk;

  sram_async_model #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn),
    .csLowN(csLowN), .csHigh(csHigh), .weN(weN), .oeN(oeN),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .writeBusy(writeBusy)
  );

  function automatic int slot(logic [AW-1:0] a);
    return int'(a) % DEPTH;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic idle();
    csLowN = 1; csHigh = 0; weN = 1; oeN = 1;
  endtask

  // one write; endMode 0=weN, 1=csLowN, 2=csHigh closes window
  task automatic doWrite(logic [AW-1:0] a, logic [DW-1:0] d, int endMode, int len, logic oe);
    logic [AW-1:0] lastA = a;
    logic [DW-1:0] lastD = d;
    @(negedge clk);
    addr = a; dataIn = d; oeN = oe;
    csLowN = 0; csHigh = 1; weN = 0;
    #1;
    check("R5 busy", writeBusy, 1);
    check("R5 nodrive", dataOutEn, 0);
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      lastA = AW'($urandom); lastD = DW'($urandom);
      addr = lastA; dataIn = lastD;  // R8 later values win
    end
    @(negedge clk);
    addr = AW'($urandom); dataIn = DW'($urandom);
    case (endMode)
      0: weN = 1;
      1: csLowN = 1;
      default: csHigh = 0;
    endcase
    #1;
    check("R6 closed", writeBusy, 0);
    @(negedge clk);
    idle();
    model[slot(lastA)] = lastD;
  endtask

  task automatic doRead(logic [AW-1:0] a, string req);
    @(negedge clk);
    addr = a; csLowN = 0; csHigh = 1; weN = 1; oeN = 0;
    #1;
    check({req, " en"}, dataOutEn, 1);
    check({req, " data"}, dataOut, model[slot(a)]);
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R9
    check("R9 en", dataOutEn, 0);
    check("R9 busy", writeBusy, 0);

    // fill array, cycling through closing signals (R6)
    for (int i = 0; i < DEPTH; i++)
      doWrite(AW'(i), DW'($urandom), i % 3, 1, 1'($urandom));
    for (int i = 0; i < 8; i++) doRead(AW'(i * 37), "R4");

    // R1 aliasing through high address bits
    doWrite(AW'(DEPTH * 5 + 9), 8'hA5, 0, 1, 1);
    doRead(AW'(9), "R1");
    doRead(AW'(DEPTH * 3 + 9), "R1");

    // R4 read follows address with no clock edge
    @(negedge clk);
    addr = AW'(20); csLowN = 0; csHigh = 1; weN = 1; oeN = 0;
    #1; check("R4 a", dataOut, model[20]);
    addr = AW'(21);
    #1; check("R4 b", dataOut, model[21]);
    idle();

    // R3 output disabled
    @(negedge clk);
    csLowN = 0; csHigh = 1; weN = 1; oeN = 1;
    #1; check("R3", dataOutEn, 0);
    idle();

    // R2 standby under all other control combinations
    for (int m = 0; m < 12; m++) begin
      @(negedge clk);
      csLowN = (m % 3) != 0; csHigh = (m % 3) == 1 ? 1'b1 : 1'b0;
      if (m % 3 == 1) csLowN = 1;
      weN = m[2]; oeN = m[3];
      #1;
      check("R2 en", dataOutEn, 0);
      check("R2 busy", writeBusy, 0);
    end
    idle();

    // R6 window opens only at the last of three
    @(negedge clk);
    addr = AW'(40); dataIn = 8'h3C; weN = 0; oeN = 1;
    #1; check("R6 open1", writeBusy, 0);
    @(negedge clk); csLowN = 0;
    #1; check("R6 open2", writeBusy, 0);
    @(negedge clk); csHigh = 1;
    #1; check("R6 open3", writeBusy, 1);
    @(negedge clk); csLowN = 1;
    @(negedge clk); idle();
    model[40] = 8'h3C;
    doRead(AW'(40), "R6");

    // R7 simultaneous fall of csLowN and weN with oeN low
    @(negedge clk);
    addr = AW'(50); dataIn = 8'h77; csHigh = 1; oeN = 0; csLowN = 1; weN = 1;
    #1; check("R7 before", dataOutEn, 0);
    csLowN = 0; weN = 0;
    #1; check("R7 during", dataOutEn, 0);
    @(negedge clk);
    #1; check("R7 held", dataOutEn, 0);
    weN = 1; csLowN = 1;
    @(negedge clk); idle();
    model[50] = 8'h77;
    doRead(AW'(50), "R7");

    // R8 multi-cycle window, last values committed
    doWrite(AW'(60), 8'h11, 2, 3, 0);
    for (int i = 0; i < DEPTH; i += 17) doRead(AW'(i), "R8");

    // random mix
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(1) == 1)
        doWrite(AW'($urandom), DW'($urandom), int'($urandom_range(2)),
                int'($urandom_range(3, 1)), 1'($urandom));
      else
        doRead(AW'($urandom), "R4 rnd");
    end
    for (int i = 0; i < DEPTH; i++) doRead(AW'(i), "R8 final");
    finishRun();
  end
endmodule